// File: doc/BRIEF.md
# PCI Target Cycle Termination Controller

This block is the control half of a simple PCI target. It watches the address phase of every bus cycle and decides whether the device claims it. Configuration cycles are claimed through the select line. I/O and memory cycles are claimed only when the matching space-enable bit is set and the address falls inside the device's window. For a claimed cycle it drives the device-select, target-ready and stop handshake lines with medium decode timing. Parity, the data path and the serial ROM engine sit outside the block.

The device spends some of its time unable to serve the bus. It is busy while the configuration ROM loads, which happens automatically when reset is released and again whenever software asks for a reload. It is also busy for a fixed number of clocks after the reset register is read. A cycle claimed while busy is retried: stop and device-select are asserted with no data moved. The block never takes part in a burst. When the initiator wants more than one data phase, the first phase completes and stop ends the cycle.

All bus-side signals in this block are active high. Inversion to the bus's active-low pins is done outside the block.

Top module: `pci_tgt_term`

## Requirements
- R1: A cycle is claimed only for command 4'b1010/4'b1011 with `cfg_sel` high, command 4'b0010/4'b0011 with `io_space_en` high and an address inside the I/O window, or command 4'b0110/4'b0111 with `mem_space_en` high and an address inside the memory window. An unclaimed cycle never asserts `tgt_devsel`, `tgt_trdy` or `tgt_stop`, and its data phases are not decoded as new address phases.
- R2: The address phase is the first rising edge at which `bus_frame` is sampled high while the block is idle. For a claimed cycle the handshake outputs stay low after that edge and change after the second edge (medium timing).
- R3: When not busy, a claimed single-phase cycle raises `tgt_devsel` and `tgt_trdy` together with `tgt_stop` low. One word moves at the edge where `bus_irdy` and `tgt_trdy` are both high, and `tgt_trdy` is low after that edge.
- R4: When busy, a claimed cycle raises `tgt_devsel` and `tgt_stop` together while `tgt_trdy` stays low for the whole cycle, so no word is moved.
- R5: Once asserted, `tgt_stop` stays high until an edge samples `bus_frame` and `bus_irdy` both low. At that edge `tgt_devsel`, `tgt_trdy` and `tgt_stop` all drop together.
- R6: The ROM-load busy state is set by reset and by a `rom_load_req` pulse, and it is cleared by a `rom_load_done` pulse.
- R7: A `reset_reg_read` pulse makes the block busy for `RST_CYC` clocks. Every claimed cycle whose address phase falls inside that window is retried, and cycles after it complete normally.
- R8: Busy is sampled at the address phase and holds for the whole cycle. A busy state that starts after the address phase does not change that cycle.
- R9: If `bus_frame` and `bus_irdy` are both high at the edge before `tgt_trdy` is asserted, `tgt_stop` rises together with `tgt_trdy`. The first data phase still completes, and exactly one word moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_frame | input | 1 | Initiator cycle-framing line, high = asserted |
| bus_irdy | input | 1 | Initiator ready, high = asserted |
| bus_cmd | input | 4 | Bus command sampled at the address phase |
| bus_addr | input | ADDR_W | Address sampled at the address phase |
| cfg_sel | input | 1 | Configuration select for this device |
| io_space_en | input | 1 | I/O space enable bit from the command register |
| mem_space_en | input | 1 | Memory space enable bit from the command register |
| rom_load_req | input | 1 | Software request pulse to reload the configuration ROM |
| rom_load_done | input | 1 | Pulse from the ROM engine marking the end of a load |
| reset_reg_read | input | 1 | Pulse marking a read of the reset register |
| tgt_devsel | output | 1 | Device select, high = asserted |
| tgt_trdy | output | 1 | Target ready, high = asserted |
| tgt_stop | output | 1 | Stop request, high = asserted |

## Verification
The bench targets the corner where a busy state and the enable bits interact. Straight after reset, an I/O cycle with its enable clear must stay silent, while a configuration cycle must be retried. A design that ignored the enable here would answer a cycle it does not own. A reset-register read pulsed after an address phase must leave that cycle untouched; a design that tracked busy live would drop target-ready part way through the cycle. A burst with both initiator lines high must move exactly one word with stop raised at once; a design that raised stop late would let a second word through. The retry path holds the initiator ready for an extra clock to show that stop is not released before the bus goes idle.

// File: rtl/pci_tgt_pkg.sv
`timescale 1ns/1ps
package pci_tgt_pkg;

   typedef enum logic [3:0] {
      CMD_IO_RD  = 4'b0010,
      CMD_IO_WR  = 4'b0011,
      CMD_MEM_RD = 4'b0110,
      CMD_MEM_WR = 4'b0111,
      CMD_CFG_RD = 4'b1010,
      CMD_CFG_WR = 4'b1011
   } bus_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_DECODE = 2'd1,
      ST_DATA   = 2'd2,
      ST_SKIP   = 2'd3
   } tgt_state_e;

endpackage

// File: rtl/pci_tgt_decode.sv
`timescale 1ns/1ps
module pci_tgt_decode #(
   parameter int                ADDR_W    = 32,
   parameter int                IO_WIN_W  = 5,
   parameter int                MEM_WIN_W = 12,
   parameter logic [ADDR_W-1:0] IO_BASE   = '0,
   parameter logic [ADDR_W-1:0] MEM_BASE  = '0
) (
   input  logic [3:0]        cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic              cfg_sel,
   input  logic              io_en,
   input  logic              mem_en,
   output logic              claim
);
   import pci_tgt_pkg::*;

   localparam logic [ADDR_W-1:0] IO_MASK  = ~((ADDR_W'(1) << IO_WIN_W)  - ADDR_W'(1));
   localparam logic [ADDR_W-1:0] MEM_MASK = ~((ADDR_W'(1) << MEM_WIN_W) - ADDR_W'(1));

   generate
      if (IO_WIN_W < 2 || IO_WIN_W >= ADDR_W) begin : g_bad_io_win
         $error("IO_WIN_W must lie in 2..ADDR_W-1");
      end
      if (MEM_WIN_W < 4 || MEM_WIN_W >= ADDR_W) begin : g_bad_mem_win
         $error("MEM_WIN_W must lie in 4..ADDR_W-1");
      end
   endgenerate

   logic io_hit;
   logic mem_hit;

   assign io_hit  = (addr & IO_MASK)  == (IO_BASE  & IO_MASK);
   assign mem_hit = (addr & MEM_MASK) == (MEM_BASE & MEM_MASK);

   always_comb begin
      case (cmd)
         CMD_CFG_RD, CMD_CFG_WR: claim = cfg_sel;
         CMD_IO_RD,  CMD_IO_WR:  claim = io_en & io_hit;
         CMD_MEM_RD, CMD_MEM_WR: claim = mem_en & mem_hit;
         default:                claim = 1'b0;
      endcase
   end

endmodule

// File: rtl/pci_tgt_busy.sv
`timescale 1ns/1ps
module pci_tgt_busy #(
   parameter int RST_CYC = 33000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_req,
   input  logic load_done,
   input  logic rst_reg_rd,
   output logic busy
);
   localparam int CNT_W = $clog2(RST_CYC + 1);

   generate
      if (RST_CYC < 1) begin : g_bad_rst_cyc
         $error("RST_CYC must be at least 1");
      end
   endgenerate

   logic             loading;
   logic [CNT_W-1:0] win_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loading <= 1'b1;
      end else if (load_req) begin
         loading <= 1'b1;
      end else if (load_done) begin
         loading <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
      end else if (rst_reg_rd) begin
         win_cnt <= CNT_W'(RST_CYC);
      end else if (win_cnt != '0) begin
         win_cnt <= win_cnt - CNT_W'(1);
      end
   end

   assign busy = loading | (win_cnt != '0);

endmodule

// File: rtl/pci_tgt_fsm.sv
`timescale 1ns/1ps
module pci_tgt_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic frame,
   input  logic irdy,
   input  logic claim,
   input  logic busy,
   output logic devsel,
   output logic trdy,
   output logic stop
);
   import pci_tgt_pkg::*;

   tgt_state_e state;
   logic       busy_q;
   logic       bus_idle;

   assign bus_idle = !frame && !irdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         busy_q <= 1'b0;
         devsel <= 1'b0;
         trdy   <= 1'b0;
         stop   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (frame) begin
                  busy_q <= busy;
                  state  <= claim ? ST_DECODE : ST_SKIP;
               end
            end
            ST_DECODE: begin
               devsel <= 1'b1;
               trdy   <= !busy_q;
               stop   <= busy_q | (frame & irdy);
               state  <= ST_DATA;
            end
            ST_DATA: begin
               if (bus_idle) begin
                  devsel <= 1'b0;
                  trdy   <= 1'b0;
                  stop   <= 1'b0;
                  state  <= ST_IDLE;
               end else if (trdy && irdy) begin
                  trdy <= 1'b0;
                  stop <= stop | frame;
               end
            end
            ST_SKIP: begin
               if (bus_idle) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pci_tgt_term.sv
`timescale 1ns/1ps
module pci_tgt_term #(
   parameter int                ADDR_W    = 32,
   parameter int                IO_WIN_W  = 5,
   parameter int                MEM_WIN_W = 12,
   parameter logic [ADDR_W-1:0] IO_BASE   = ADDR_W'(32'h0000_0400),
   parameter logic [ADDR_W-1:0] MEM_BASE  = ADDR_W'(32'hF000_0000),
   parameter int                RST_CYC   = 33000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_frame,
   input  logic              bus_irdy,
   input  logic [3:0]        bus_cmd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              cfg_sel,
   input  logic              io_space_en,
   input  logic              mem_space_en,
   input  logic              rom_load_req,
   input  logic              rom_load_done,
   input  logic              reset_reg_read,
   output logic              tgt_devsel,
   output logic              tgt_trdy,
   output logic              tgt_stop
);

   logic claim;
   logic busy;

   pci_tgt_decode #(
      .ADDR_W   (ADDR_W),
      .IO_WIN_W (IO_WIN_W),
      .MEM_WIN_W(MEM_WIN_W),
      .IO_BASE  (IO_BASE),
      .MEM_BASE (MEM_BASE)
   ) u_decode (
      .cmd    (bus_cmd),
      .addr   (bus_addr),
      .cfg_sel(cfg_sel),
      .io_en  (io_space_en),
      .mem_en (mem_space_en),
      .claim  (claim)
   );

   pci_tgt_busy #(
      .RST_CYC(RST_CYC)
   ) u_busy (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_req  (rom_load_req),
      .load_done (rom_load_done),
      .rst_reg_rd(reset_reg_read),
      .busy      (busy)
   );

   pci_tgt_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .frame (bus_frame),
      .irdy  (bus_irdy),
      .claim (claim),
      .busy  (busy),
      .devsel(tgt_devsel),
      .trdy  (tgt_trdy),
      .stop  (tgt_stop)
   );

endmodule

// File: rtl/pci_tgt_term_chk.sv
`timescale 1ns/1ps
module pci_tgt_term_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_frame,
   input logic bus_irdy,
   input logic tgt_devsel,
   input logic tgt_trdy,
   input logic tgt_stop
);

   // R3: target-ready is never driven without device-select
   p_trdy_in_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_trdy |-> tgt_devsel);

   // R4: stop is only driven inside a claimed cycle
   p_stop_in_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_stop |-> tgt_devsel);

   // R4: a claim that does not offer data must be a retry
   p_retry_on_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tgt_devsel) && !tgt_trdy) |-> tgt_stop);

   // R5: stop is held while the initiator keeps either line asserted
   p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_stop && (bus_frame || bus_irdy)) |=> tgt_stop);

   // R9: initiator lines both high before ready means stop rises with ready
   p_burst_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tgt_trdy) && $past(bus_frame && bus_irdy)) |-> tgt_stop);

   // R9: after one word moves, target-ready is withdrawn
   p_one_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_trdy && bus_irdy) |=> !tgt_trdy);

endmodule

bind pci_tgt_term pci_tgt_term_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_frame (bus_frame),
   .bus_irdy  (bus_irdy),
   .tgt_devsel(tgt_devsel),
   .tgt_trdy  (tgt_trdy),
   .tgt_stop  (tgt_stop)
);

// File: tb/pci_tgt_term_tb_top.sv
`timescale 1ns/1ps
module pci_tgt_term_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int RST_CYC    = 40;
   localparam int WATCHDOG   = 20000;

   localparam logic [3:0] C_IO_RD  = 4'b0010;
   localparam logic [3:0] C_IO_WR  = 4'b0011;
   localparam logic [3:0] C_MEM_WR = 4'b0111;
   localparam logic [3:0] C_CFG_RD = 4'b1010;
   localparam logic [3:0] C_CFG_WR = 4'b1011;

   localparam logic [31:0] IO_ADDR  = 32'h0000_0408;
   localparam logic [31:0] IO_MISS  = 32'h0000_0820;
   localparam logic [31:0] MEM_ADDR = 32'hF000_0123;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_frame = 1'b0;
   logic        bus_irdy = 1'b0;
   logic [3:0]  bus_cmd = 4'h0;
   logic [31:0] bus_addr = '0;
   logic        cfg_sel = 1'b0;
   logic        io_space_en = 1'b0;
   logic        mem_space_en = 1'b0;
   logic        rom_load_req = 1'b0;
   logic        rom_load_done = 1'b0;
   logic        reset_reg_read = 1'b0;
   logic        tgt_devsel;
   logic        tgt_trdy;
   logic        tgt_stop;

   int n_checks = 0;
   int n_fail   = 0;
   int xfers    = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pci_tgt_term #(
      .ADDR_W   (32),
      .IO_WIN_W (5),
      .MEM_WIN_W(12),
      .IO_BASE  (32'h0000_0400),
      .MEM_BASE (32'hF000_0000),
      .RST_CYC  (RST_CYC)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_frame     (bus_frame),
      .bus_irdy      (bus_irdy),
      .bus_cmd       (bus_cmd),
      .bus_addr      (bus_addr),
      .cfg_sel       (cfg_sel),
      .io_space_en   (io_space_en),
      .mem_space_en  (mem_space_en),
      .rom_load_req  (rom_load_req),
      .rom_load_done (rom_load_done),
      .reset_reg_read(reset_reg_read),
      .tgt_devsel    (tgt_devsel),
      .tgt_trdy      (tgt_trdy),
      .tgt_stop      (tgt_stop)
   );

   always @(posedge clk) begin
      if (bus_irdy && tgt_trdy) xfers <= xfers + 1;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // One bus cycle; checks every phase against the expected outcome.
   task automatic bus_cycle(input logic [3:0] cmd, input logic [31:0] addr,
                            input bit sel, input bit burst, input bit exp_claim,
                            input bit exp_retry, input bit mid_pulse, input string req);
      int start;
      start = xfers;
      @(negedge clk);
      bus_frame = 1'b1; bus_cmd = cmd; bus_addr = addr; cfg_sel = sel;
      @(negedge clk);                               // after address edge
      chk("R2", {req, " devsel quiet after address edge"}, int'(tgt_devsel), 0);
      bus_frame = burst; bus_irdy = 1'b1; cfg_sel = 1'b0;
      reset_reg_read = mid_pulse;
      @(negedge clk);                               // after second edge
      reset_reg_read = 1'b0;
      if (!exp_claim) begin
         chk(req, "unclaimed devsel", int'(tgt_devsel), 0);
         chk(req, "unclaimed trdy/stop", int'(tgt_trdy | tgt_stop), 0);
         bus_frame = 1'b0;
         @(negedge clk);
         chk(req, "unclaimed devsel late", int'(tgt_devsel), 0);
         bus_irdy = 1'b0;
         @(negedge clk);
         chk(req, "unclaimed no word", xfers - start, 0);
         return;
      end
      chk(req, "devsel on second edge", int'(tgt_devsel), 1);
      chk(req, "trdy at claim", int'(tgt_trdy), exp_retry ? 0 : 1);
      chk(req, "stop at claim", int'(tgt_stop), (exp_retry || burst) ? 1 : 0);
      bus_frame = 1'b0;
      @(negedge clk);
      chk(req, "trdy after phase", int'(tgt_trdy), 0);
      chk(req, "devsel held", int'(tgt_devsel), 1);
      if (exp_retry) chk("R5", {req, " stop held while irdy"}, int'(tgt_stop), 1);
      bus_irdy = 1'b0;
      @(negedge clk);
      chk("R5", {req, " release on idle"},
          int'({tgt_devsel, tgt_trdy, tgt_stop}), 0);
      chk(req, "words moved", xfers - start, exp_retry ? 0 : 1);
   endtask

   task automatic t_reset_state();
      repeat (3) @(negedge clk);
      chk("R5", "outputs low in reset", int'({tgt_devsel, tgt_trdy, tgt_stop}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R5", "outputs low after reset", int'({tgt_devsel, tgt_trdy, tgt_stop}), 0);
   endtask

   task automatic t_boot_load_busy();
      // R6: load in progress from reset: config retried
      bus_cycle(C_CFG_RD, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R6 boot cfg retry");
      // R1: I/O disabled by reset, not claimed even while busy
      bus_cycle(C_IO_RD, IO_ADDR, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 io disabled");
      @(negedge clk); rom_load_done = 1'b1;
      @(negedge clk); rom_load_done = 1'b0;
   endtask

   task automatic t_single_cycles();
      bus_cycle(C_CFG_RD, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 cfg read");
      bus_cycle(C_CFG_WR, 32'h4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 cfg write");
      bus_cycle(C_CFG_RD, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 cfg no select");
      io_space_en = 1'b1; mem_space_en = 1'b1;
      bus_cycle(C_IO_WR,  IO_ADDR,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3 io write");
      bus_cycle(C_IO_RD,  IO_MISS,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 io window miss");
      bus_cycle(C_MEM_WR, MEM_ADDR, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3 mem write");
      mem_space_en = 1'b0;
      bus_cycle(C_MEM_WR, MEM_ADDR, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 mem disabled");
   endtask

   task automatic t_bursts();
      bus_cycle(C_CFG_RD, 32'h8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9 cfg burst");
      bus_cycle(C_IO_RD,  IO_ADDR, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 io burst");
   endtask

   task automatic t_reset_window();
      // R8: pulse after the address phase leaves this cycle normal
      bus_cycle(C_IO_RD, IO_ADDR, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8 busy mid cycle");
      bus_cycle(C_CFG_RD, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7 window cfg retry");
      bus_cycle(C_IO_WR, IO_ADDR, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7 window io retry");
      repeat (RST_CYC) @(negedge clk);
      bus_cycle(C_IO_WR, IO_ADDR, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 window over");
   endtask

   task automatic t_soft_load();
      @(negedge clk); rom_load_req = 1'b1;
      @(negedge clk); rom_load_req = 1'b0;
      bus_cycle(C_CFG_WR, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R6 soft load retry");
      @(negedge clk); rom_load_done = 1'b1;
      @(negedge clk); rom_load_done = 1'b0;
      bus_cycle(C_CFG_WR, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 load finished");
   endtask

   initial begin
      t_reset_state();
      t_boot_load_busy();
      t_single_cycles();
      t_bursts();
      t_reset_window();
      t_soft_load();
      repeat (3) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule